// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two pieces of state. The first is a shift register that holds the outcomes of the most recently resolved branches. The second is a table of 2-bit confidence counters. A lookup XORs the low bits of the fetch address with the history register. The result selects one counter, and the counter's high bit is the guess. Because the history is part of the index, one branch can learn a different direction in each context set up by the branches before it.

The front end presents low address bits on the lookup port in the same cycle it needs the answer. It keeps the returned table index alongside the in-flight branch. When the branch resolves, the back end returns that index together with the real outcome. The block then trains the named counter and shifts the outcome into the history. A build-time parameter picks one of two training rules:
- a plain saturating up/down counter;
- a direction-plus-confidence pair, in which a flipped direction starts out confident.

Top module: `gshare_dir_pred`

## Requirements
- R1: `look_idx_o` equals `look_pc_i` XOR the current history register, in the same cycle. `look_taken_o` is bit 1 of the counter at that index.
- R2: On every cycle with `train_vld_i` high, the history shifts left by one. Bit 0 takes the outcome (1 = taken) and the oldest bit is dropped. Without `train_vld_i` the history holds.
- R3: After reset, every counter holds 2'b01 and the history is all zeros. Every lookup then returns not taken, with an index equal to the address bits.
- R4: In saturating mode (`RULE = CTR_SAT`), a taken outcome adds one to the counter and stops at 2'b11. A not-taken outcome subtracts one and stops at 2'b00.
- R5: In hysteresis mode (`RULE = CTR_HYST`), the counter is {direction, confidence}. An outcome that matches the direction bit leaves the direction unchanged and sets confidence to 1.
- R6: In hysteresis mode, a wrong outcome with confidence 1 only clears confidence. A wrong outcome with confidence 0 inverts direction and sets confidence to 1. So 2'b10 trained not taken becomes 2'b01, and 2'b01 trained taken becomes 2'b00.
- R7: In both modes, starting from a confident state (2'b11 or 2'b00 when saturating, confidence 1 with hysteresis), one wrong outcome does not change the guess. A second wrong outcome in a row does.
- R8: Training writes the counter named by `train_idx_i`, whatever the history has become since the lookup. No other counter changes.
- R9: When a lookup and a training write hit the same counter in one cycle, the lookup returns the value from before the write. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| look_pc_i | input | IDX_W | Low address bits of the branch being fetched |
| look_taken_o | output | 1 | Guess: 1 taken, 0 not taken |
| look_idx_o | output | IDX_W | Table index used for this guess, to be kept with the branch |
| train_vld_i | input | 1 | A resolved branch is presented this cycle |
| train_idx_i | input | IDX_W | Index returned by the lookup of that branch |
| train_taken_i | input | 1 | Resolved outcome: 1 taken |

## Verification
Both counter rules are instantiated side by side and driven with the same stimulus, so each training sequence is compared under both rules.

Directed sequences separate the two rules. They run an entry up to confident taken and then apply two misses, which shows that two misses are needed to flip the guess. A taken outcome after a flip to not taken shows whether the flipped state starts weak or confident.

A stale-index case checks that a write lands on the index captured at lookup time and not on the one implied by the current history. Lookups that hit the entry being written in the same cycle check that the old value is returned.

Long random runs confined to a few entries mix lookups with training. They check the index arithmetic and the shifting of the history against a reference model of both rules.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    // counter training rule
    typedef enum logic {
        CTR_SAT  = 1'b0,
        CTR_HYST = 1'b1
    } ctr_rule_e;

    typedef logic [1:0] ctr_t;

    // weakly not taken when saturating, confident not taken with hysteresis
    localparam ctr_t CTR_INIT = 2'b01;

endpackage

// File: rtl/gshare_ctr_next.sv
module gshare_ctr_next
    import gshare_pkg::*;
#(
    parameter ctr_rule_e RULE = CTR_SAT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  ctr_t cur_i,
    input  logic taken_i,
    output ctr_t nxt_o
);

    logic miss;
    assign miss = (cur_i[1] != taken_i);

    generate
        if (RULE == CTR_SAT) begin : g_sat
            always_comb begin
                nxt_o = cur_i;
                if (taken_i) begin
                    if (cur_i != 2'b11) nxt_o = cur_i + 2'd1;
                end else begin
                    if (cur_i != 2'b00) nxt_o = cur_i - 2'd1;
                end
            end

            // R4: the counter moves toward the outcome, never away from it
            p_sat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                en_i |-> (taken_i ? (nxt_o >= cur_i) : (nxt_o <= cur_i)));

            // R7: one miss from a saturated state keeps the guess
            p_sat_two_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && miss && (cur_i[1] == cur_i[0])) |-> (nxt_o[1] == cur_i[1]));
        end else begin : g_hyst
            always_comb begin
                nxt_o = cur_i;
                if (!miss) begin
                    nxt_o = {cur_i[1], 1'b1};
                end else if (cur_i[0]) begin
                    nxt_o = {cur_i[1], 1'b0};
                end else begin
                    nxt_o = {~cur_i[1], 1'b1};
                end
            end

            // R5: a correct guess leaves a confident counter in the same direction
            p_hyst_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && !miss) |-> (nxt_o[0] && (nxt_o[1] == cur_i[1])));

            // R6: a direction change always lands confident
            p_hyst_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && (nxt_o[1] != cur_i[1])) |-> nxt_o[0]);

            // R7: one miss from a confident state keeps the guess
            p_hyst_two_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (en_i && miss && cur_i[0]) |-> (nxt_o[1] == cur_i[1]));
        end
    endgenerate

endmodule

// File: rtl/gshare_hist.sv
module gshare_hist #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_o
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o = st_q.hist;

    // R2: no resolved branch, no history change
    p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(hist_o));

    // R2: the newest outcome appears at the bottom and the rest move up
    p_hist_age_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (hist_o[0] == $past(bit_i)) &&
                    (hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0])));

endmodule

// File: rtl/gshare_table.sv
module gshare_table
    import gshare_pkg::*;
#(
    parameter int        IDX_W = 8,
    parameter ctr_rule_e RULE  = CTR_SAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i,
    output ctr_t             rd_ctr_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_taken_i
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    ctr_t       wr_cur;
    ctr_t       wr_nxt;

    assign wr_cur = st_q.ctr[wr_idx_i];

    gshare_ctr_next #(
        .RULE (RULE)
    ) u_ctr_next (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (wr_en_i),
        .cur_i   (wr_cur),
        .taken_i (wr_taken_i),
        .nxt_o   (wr_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ctr[wr_idx_i] = wr_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{CTR_INIT}};
        end else begin
            st_q <= st_d;
        end
    end

    // read from the registered array: a same-cycle write is seen one cycle later
    assign rd_ctr_o = st_q.ctr[rd_idx_i];

    // R8: without a training request no counter moves
    p_tbl_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q));

    // R9: the value read this cycle is the one held before any write this cycle
    p_tbl_old_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (rd_idx_i == wr_idx_i)) |-> (rd_ctr_o == wr_cur));

endmodule

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred
    import gshare_pkg::*;
#(
    parameter int        IDX_W = 8,
    parameter ctr_rule_e RULE  = CTR_SAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_pc_i,
    output logic             look_taken_o,
    output logic [IDX_W-1:0] look_idx_o,
    input  logic             train_vld_i,
    input  logic [IDX_W-1:0] train_idx_i,
    input  logic             train_taken_i
);

    logic [IDX_W-1:0] hist;
    ctr_t             look_ctr;

    gshare_hist #(
        .HIST_W (IDX_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (train_vld_i),
        .bit_i   (train_taken_i),
        .hist_o  (hist)
    );

    assign look_idx_o = look_pc_i ^ hist;

    gshare_table #(
        .IDX_W (IDX_W),
        .RULE  (RULE)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (look_idx_o),
        .rd_ctr_o   (look_ctr),
        .wr_en_i    (train_vld_i),
        .wr_idx_i   (train_idx_i),
        .wr_taken_i (train_taken_i)
    );

    assign look_taken_o = look_ctr[1];

    // R1: an all-zero address looks up exactly the history value
    p_idx_hist_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (look_pc_i == '0) |-> (look_idx_o == hist));

endmodule

// File: tb/gshare_dir_pred_tb.sv
module gshare_dir_pred_tb;
    import gshare_pkg::*;

    localparam int IW = 8;
    localparam int N  = 1 << IW;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          rst_n;
    logic [IW-1:0] pc, uidx;
    logic          uv, ut;
    logic          s_taken, h_taken;
    logic [IW-1:0] s_idx, h_idx;

    gshare_dir_pred #(.IDX_W(IW), .RULE(CTR_SAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .look_pc_i(pc), .look_taken_o(s_taken),
        .look_idx_o(s_idx), .train_vld_i(uv), .train_idx_i(uidx), .train_taken_i(ut));

    gshare_dir_pred #(.IDX_W(IW), .RULE(CTR_HYST)) u_dut_hy (
        .clk(clk), .rst_n(rst_n), .look_pc_i(pc), .look_taken_o(h_taken),
        .look_idx_o(h_idx), .train_vld_i(uv), .train_idx_i(uidx), .train_taken_i(ut));

    logic [1:0]    ms [N];
    logic [1:0]    mh [N];
    logic [IW-1:0] mhist;
    int checks = 0;
    int fails  = 0;

    function automatic logic [1:0] sat_f(logic [1:0] c, logic t);
        if (t) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    function automatic logic [1:0] hyst_f(logic [1:0] c, logic t);
        if (c[1] == t) return {c[1], 1'b1};
        if (c[0])      return {c[1], 1'b0};
        return {~c[1], 1'b1};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [IW-1:0] p, input logic v, input logic [IW-1:0] i,
                        input logic t, input string rq_i, input string rq_s, input string rq_h);
        logic [IW-1:0] e;
        @(negedge clk);
        pc = p; uv = v; uidx = i; ut = t;
        #2;
        e = p ^ mhist;
        chk(rq_i, s_idx, e);
        chk(rq_i, h_idx, e);
        chk(rq_s, s_taken, ms[e][1]);
        chk(rq_h, h_taken, mh[e][1]);
        @(posedge clk);
        #1;
        if (v) begin
            ms[i] = sat_f(ms[i], t);
            mh[i] = hyst_f(mh[i], t);
            mhist = {mhist[IW-2:0], t};
        end
    endtask

    // lookup of entry e without training
    task automatic peek(input logic [IW-1:0] e, input string rq_s, input string rq_h);
        step(e ^ mhist, 1'b0, '0, 1'b0, "R1", rq_s, rq_h);
    endtask

    // train entry e while looking it up in the same cycle (R9)
    task automatic train(input logic [IW-1:0] e, input logic t);
        step(e ^ mhist, 1'b1, e, t, "R1", "R9", "R9");
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < N; k++) begin
            ms[k] = 2'b01;
            mh[k] = 2'b01;
        end
        mhist = '0;
        rst_n = 1'b0; pc = '0; uv = 1'b0; uidx = '0; ut = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state, index equals address, guess not taken
        step(8'h35, 1'b0, '0, 1'b0, "R3", "R3", "R3");
        chk("R3", s_taken, 0);
        chk("R3", h_idx, 8'h35);

        // R4/R5/R6: drive entry 5A to confident taken under both rules
        train(8'h5A, 1'b1);
        train(8'h5A, 1'b1);
        peek(8'h5A, "R4", "R6");
        // R7: first miss keeps taken, second flips
        train(8'h5A, 1'b0);
        peek(8'h5A, "R7", "R7");
        train(8'h5A, 1'b0);
        peek(8'h5A, "R7", "R6");
        // R6: after flip, hysteresis is confident so one taken keeps not taken
        train(8'h5A, 1'b1);
        peek(8'h5A, "R4", "R6");
        train(8'h5A, 1'b1);
        peek(8'h5A, "R4", "R6");
        // R5: correct guess from weak taken restores confidence
        train(8'h5A, 1'b0);
        train(8'h5A, 1'b1);
        train(8'h5A, 1'b0);
        peek(8'h5A, "R4", "R5");

        // R2: history visible as index of address zero
        step('0, 1'b0, '0, 1'b0, "R2", "R1", "R1");

        // R8: stale index is written as given, after the history has moved on
        step(8'h11, 1'b1, 8'h07, 1'b1, "R2", "R1", "R1");
        step(8'h22, 1'b1, 8'h08, 1'b0, "R2", "R1", "R1");
        step(8'h33, 1'b1, 8'h09, 1'b1, "R2", "R1", "R1");
        step(8'hC3 ^ mhist, 1'b1, 8'hC3, 1'b1, "R2", "R8", "R8");
        step(8'h44, 1'b1, 8'hC3, 1'b1, "R2", "R8", "R8");
        peek(8'hC3, "R8", "R8");
        peek(8'hC3 ^ 8'h0B, "R8", "R8");

        // random mix over a small set of entries
        for (int n = 0; n < 4000; n++) begin
            logic [IW-1:0] rp, ri;
            logic rv, rt;
            rp = IW'($urandom);
            rv = 1'($urandom);
            ri = IW'($urandom % 16);
            rt = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) rp = ri ^ mhist;
            step(rp, rv, ri, rt, "R1", "R4", "R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule